// File: doc/BRIEF.md
# Event Word Queue with Host Register Port

This block buffers event words produced by trigger logic and hands them to a host over a small 32-bit register port. Trigger logic offers one word per cycle on a push strobe. The words are kept in a synchronous first-in first-out store until the host fetches them. The host reaches four register addresses with a request strobe, a write flag, a two-bit address and write data. Every request gets a one-cycle acknowledge, which carries the read data when the access is a read.

The host finds out how full the queue is from a status word. That word holds five flags at fixed bit positions: empty, almost empty, almost full, full, and a programmable-full flag set against a threshold that the host can write. Reading the data address takes one word from the head of the queue. Any write to the status address empties the queue. If trigger logic pushes while the queue is full, the word is lost and a sticky overflow bit is set. The host can read that bit at its own address.

Top module: `event_queue_slave`

## Requirements
- R1: After reset, the following hold. `bus_ack` is low. A status read returns 0x3 (empty and almost empty). A threshold read returns DEPTH-4. An overflow read returns 0.
- R2: A cycle with `bus_req` high makes `bus_ack` high in the next cycle. A cycle with `bus_req` low makes `bus_ack` low in the next cycle.
- R3: The queue stores a push when it is not full. Each read of address 1 (data) returns the oldest stored word and removes it, so words come out in push order.
- R4: A read of address 1 while the queue is empty returns 0 and leaves the queue and its flags unchanged.
- R5: In the status word at address 0, bit 0 is set when the queue holds no word. Bit 1 is set when it holds one word or none.
- R6: Status bit 2 is set when the queue holds DEPTH-1 words or more. Status bit 3 is set when it holds DEPTH words.
- R7: Status bit 4 is set when the stored count is greater than or equal to the 32-bit threshold at address 2. Writes to address 2 change the threshold, and reads of address 2 return it.
- R8: Status bits 31 down to 5 always read as zero.
- R9: Any write to address 0 empties the queue and clears the overflow bit, whatever data is written. This clear takes priority over a push or pop in the same cycle.
- R10: A push while the queue is full is dropped, even when a pop happens in the same cycle. The drop sets bit 0 of address 3 (overflow), and the bit stays set until a clear. Writes to address 3 have no effect.
- R11: A push and a data read in the same cycle on a queue that is neither empty nor full leave the stored count unchanged.
- R12: A write to address 1 adds nothing to the queue and removes nothing from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_req | input | 1 | Host access request, one access per cycle it is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 status/clear, 1 data, 2 threshold, 3 overflow |
| bus_wdata | input | 32 | Host write data |
| bus_ack | output | 1 | Acknowledge, high one cycle after each request cycle |
| bus_rdata | output | 32 | Read data, valid while `bus_ack` is high after a read, 0 otherwise |
| push_valid | input | 1 | Trigger logic offers a word this cycle |
| push_data | input | 32 | Event word to store |

## Verification
All results are registered, so they fall due one cycle after the request. An access sampled at one rising edge shows its acknowledge and read data between that edge and the next. The returned value reflects the queue as it stood just before that edge. Pushes, pops, clears and threshold writes at that edge show up only in a read issued in a later cycle. The bench drives inputs on falling edges and updates a queue-based reference model at each rising edge with the same inputs. It compares acknowledge and read data at the following falling edge, which is the moment the due result is stable.

// File: rtl/evq_pkg.sv
`timescale 1ns/1ps
package evq_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_DATA   = 2'd1,
    REG_THRESH = 2'd2,
    REG_OVF    = 2'd3
  } evq_reg_e;

  localparam int ST_EMPTY  = 0;
  localparam int ST_AEMPTY = 1;
  localparam int ST_AFULL  = 2;
  localparam int ST_FULL   = 3;
  localparam int ST_PFULL  = 4;
  localparam int ST_W      = 5;
endpackage

// File: rtl/evq_store.sv
`timescale 1ns/1ps
module evq_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5,
  parameter int PTR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_word,
  output logic [CNT_W-1:0]  fill,
  output logic              ovf
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]  fill_q, fill_d;
  logic              ovf_q, ovf_d;
  logic              take_push, take_pop, mem_we;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    take_push = push && (fill_q != FULL_CNT);
    take_pop  = pop && (fill_q != '0);
    mem_we    = take_push && !clear;
    if (clear) begin
      wr_d   = '0;
      rd_d   = '0;
      fill_d = '0;
      ovf_d  = 1'b0;
    end else begin
      wr_d   = take_push ? ptr_inc(wr_q) : wr_q;
      rd_d   = take_pop  ? ptr_inc(rd_q) : rd_q;
      fill_d = fill_q + CNT_W'(take_push) - CNT_W'(take_pop);
      ovf_d  = ovf_q | (push && !take_push);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      fill_q <= fill_d;
      ovf_q  <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) begin
      mem[wr_q] <= push_data;
    end
  end

  assign head_word = mem[rd_q];
  assign fill      = fill_q;
  assign ovf       = ovf_q;
endmodule

// File: rtl/evq_flags.sv
`timescale 1ns/1ps
module evq_flags
  import evq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5
) (
  input  logic [CNT_W-1:0]  fill,
  input  logic [DATA_W-1:0] thresh,
  output logic [ST_W-1:0]   status
);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] AFULL_CNT = CNT_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] ONE_CNT   = CNT_W'(1);

  logic [DATA_W-1:0] fill_wide;

  always_comb begin
    fill_wide         = DATA_W'(fill);
    status            = '0;
    status[ST_EMPTY]  = (fill == '0);
    status[ST_AEMPTY] = (fill <= ONE_CNT);
    status[ST_AFULL]  = (fill >= AFULL_CNT);
    status[ST_FULL]   = (fill == FULL_CNT);
    status[ST_PFULL]  = (fill_wide >= thresh);
  end
endmodule

// File: rtl/evq_bus.sv
`timescale 1ns/1ps
module evq_bus
  import evq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [ST_W-1:0]   status,
  input  logic [DATA_W-1:0] head_word,
  input  logic [CNT_W-1:0]  fill,
  input  logic              ovf,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              clear,
  output logic              pop,
  output logic [DATA_W-1:0] thresh
);
  localparam logic [DATA_W-1:0] THRESH_RST = DATA_W'(DEPTH - 4);

  evq_reg_e          sel;
  logic              rd_req, wr_req, thr_we;
  logic              ack_q;
  logic [DATA_W-1:0] rdata_q, rdata_d, thresh_q;

  always_comb begin
    sel     = evq_reg_e'(bus_addr);
    rd_req  = bus_req && !bus_we;
    wr_req  = bus_req && bus_we;
    clear   = wr_req && (sel == REG_CTRL);
    thr_we  = wr_req && (sel == REG_THRESH);
    pop     = rd_req && (sel == REG_DATA) && (fill != '0);
    rdata_d = '0;
    if (rd_req) begin
      case (sel)
        REG_CTRL:   rdata_d = DATA_W'(status);
        REG_DATA:   rdata_d = (fill != '0) ? head_word : '0;
        REG_THRESH: rdata_d = thresh_q;
        REG_OVF:    rdata_d = DATA_W'(ovf);
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= bus_req;
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thresh_q <= THRESH_RST;
    end else if (thr_we) begin
      thresh_q <= bus_wdata;
    end
  end

  assign bus_ack   = ack_q;
  assign bus_rdata = rdata_q;
  assign thresh    = thresh_q;
endmodule

// File: rtl/event_queue_slave.sv
`timescale 1ns/1ps
module event_queue_slave
  import evq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [1:0]        rst_pipe;
  logic              core_rst_n;
  logic              clear, pop, ovf_flag;
  logic [CNT_W-1:0]  fill_cnt;
  logic [DATA_W-1:0] head_word, thresh;
  logic [ST_W-1:0]   status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign core_rst_n = rst_pipe[1];

  evq_store #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)
  ) i_store (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .clear     (clear),
    .push      (push_valid),
    .push_data (push_data),
    .pop       (pop),
    .head_word (head_word),
    .fill      (fill_cnt),
    .ovf       (ovf_flag)
  );

  evq_flags #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) i_flags (
    .fill   (fill_cnt),
    .thresh (thresh),
    .status (status)
  );

  evq_bus #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) i_bus (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .status    (status),
    .head_word (head_word),
    .fill      (fill_cnt),
    .ovf       (ovf_flag),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .clear     (clear),
    .pop       (pop),
    .thresh    (thresh)
  );
endmodule

// File: rtl/evq_checker.sv
`timescale 1ns/1ps
module evq_checker #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [1:0]        bus_addr,
  input logic              bus_ack,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              push,
  input logic [CNT_W-1:0]  fill,
  input logic              ovf
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic clr_acc, data_rd, stat_rd;
  assign clr_acc = bus_req && bus_we && (bus_addr == 2'd0);
  assign data_rd = bus_req && !bus_we && (bus_addr == 2'd1);
  assign stat_rd = bus_req && !bus_we && (bus_addr == 2'd0);

  a_r2_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_ack);
  a_r2_no_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !bus_ack);
  a_r8_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (bus_rdata[DATA_W-1:5] == '0));
  a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && fill == '0) |=> (bus_rdata == '0));
  a_r6_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL_CNT);
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_acc |=> (fill == '0 && !ovf));
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr_acc) |=> ovf);
  a_r10_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == FULL_CNT && !clr_acc && !data_rd) |=> (fill == FULL_CNT));
  a_r11_push_pop_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (fill != '0 && fill != FULL_CNT && push && data_rd) |=> $stable(fill));
endmodule

bind event_queue_slave evq_checker #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) i_evq_chk (
  .clk       (clk),
  .rst_n     (core_rst_n),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_ack   (bus_ack),
  .bus_rdata (bus_rdata),
  .push      (push_valid),
  .fill      (fill_cnt),
  .ovf       (ovf_flag)
);

// File: tb/test_event_queue_slave.sv
`timescale 1ns/1ps
module test_event_queue_slave;
  localparam int DW    = 32;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0;
  logic          bus_we = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic [DW-1:0] bus_wdata = '0;
  logic          push_valid = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic          bus_ack;
  logic [DW-1:0] bus_rdata;

  int errors = 0;
  int checks = 0;
  bit chk_on = 1'b0;

  logic [DW-1:0] q[$];
  logic [DW-1:0] m_thr;
  logic          m_ovf;
  logic          m_ack;
  logic [DW-1:0] m_rdata;
  logic [DW-1:0] m_st;
  string         m_tag;
  int            n;

  always #2.5 clk = ~clk;

  event_queue_slave #(.DATA_W(DW), .DEPTH(DEPTH)) i_event_queue_slave (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .push_valid(push_valid), .push_data(push_data)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model: queue behaviour from the requirements, updated per edge
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_thr   = DW'(DEPTH - 4);
      m_ovf   = 1'b0;
      m_ack   = 1'b0;
      m_rdata = '0;
      m_tag   = "R1";
    end else begin
      n       = q.size();
      m_st    = '0;
      m_st[0] = (n == 0);
      m_st[1] = (n <= 1);
      m_st[2] = (n >= DEPTH - 1);
      m_st[3] = (n == DEPTH);
      m_st[4] = (DW'(n) >= m_thr);
      m_ack   = bus_req;
      m_rdata = '0;
      if (bus_req && !bus_we) begin
        case (bus_addr)
          2'd0: begin m_rdata = m_st; m_tag = "R5 R6 R7 R8 status"; end
          2'd1: begin m_rdata = (n > 0) ? q[0] : '0; m_tag = "R3 R4 R11 data"; end
          2'd2: begin m_rdata = m_thr; m_tag = "R7 threshold"; end
          default: begin m_rdata = DW'(m_ovf); m_tag = "R10 overflow"; end
        endcase
      end
      if (bus_req && bus_we && bus_addr == 2'd0) begin
        q.delete();
        m_ovf = 1'b0;
      end else begin
        if (bus_req && !bus_we && bus_addr == 2'd1 && n > 0) void'(q.pop_front());
        if (push_valid) begin
          if (n < DEPTH) q.push_back(push_data);
          else m_ovf = 1'b1;
        end
      end
      if (bus_req && bus_we && bus_addr == 2'd2) m_thr = bus_wdata;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      chk(bus_ack === m_ack, "R2 ack", DW'(bus_ack), DW'(m_ack));
      if (m_ack) chk(bus_rdata === m_rdata, m_tag, bus_rdata, m_rdata);
    end
  end

  task automatic rd_expect(input logic [1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    chk(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic push_word(input logic [DW-1:0] d);
    @(negedge clk);
    push_valid = 1'b1; push_data = d;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_on = 1'b1;
    // R1 reset state
    chk(bus_ack === 1'b0, "R1 ack idle", DW'(bus_ack), 0);
    rd_expect(2'd0, 32'h3, "R1 status");
    rd_expect(2'd2, DW'(DEPTH - 4), "R1 threshold");
    rd_expect(2'd3, 32'h0, "R1 overflow");
    // R4 empty read
    rd_expect(2'd1, 32'h0, "R4 empty data");
    rd_expect(2'd0, 32'h3, "R4 flags unchanged");
    // R3 ordering
    for (int i = 0; i < 5; i++) push_word(32'hA000 + DW'(i));
    rd_expect(2'd0, 32'h0, "R5 five words");
    for (int i = 0; i < 5; i++) rd_expect(2'd1, 32'hA000 + DW'(i), "R3 order");
    // R5 single word, R12 write to data ignored
    push_word(32'hBEEF);
    rd_expect(2'd0, 32'h2, "R5 one word");
    wr(2'd1, 32'h1234);
    rd_expect(2'd0, 32'h2, "R12 status");
    rd_expect(2'd1, 32'hBEEF, "R12 head");
    rd_expect(2'd1, 32'h0, "R12 nothing added");
    // R9 clear with arbitrary data
    push_word(32'h1);
    wr(2'd0, 32'hFFFF_FFFF);
    rd_expect(2'd0, 32'h3, "R9 clear");
    // R6, R7, R10 filling
    for (int i = 0; i < DEPTH - 1; i++) push_word(32'h100 + DW'(i));
    rd_expect(2'd0, 32'h14, "R6 R7 almost full");
    push_word(32'h10F);
    rd_expect(2'd0, 32'h1C, "R6 full");
    push_word(32'hDEAD);
    rd_expect(2'd3, 32'h1, "R10 overflow set");
    wr(2'd3, 32'h0);
    rd_expect(2'd3, 32'h1, "R10 write ignored");
    rd_expect(2'd1, 32'h100, "R10 head kept");
    rd_expect(2'd0, 32'h14, "R6 after pop");
    wr(2'd0, 32'h0);
    rd_expect(2'd3, 32'h0, "R9 overflow cleared");
    // R7 threshold
    wr(2'd2, 32'h3);
    rd_expect(2'd2, 32'h3, "R7 readback");
    push_word(32'h51); push_word(32'h52);
    rd_expect(2'd0, 32'h0, "R7 below threshold");
    push_word(32'h53);
    rd_expect(2'd0, 32'h10, "R7 at threshold");
    // R11 push and pop together
    @(negedge clk);
    push_valid = 1'b1; push_data = 32'h54;
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 2'd1;
    @(negedge clk);
    push_valid = 1'b0; bus_req = 1'b0;
    chk(bus_rdata === 32'h51, "R11 head", bus_rdata, 32'h51);
    rd_expect(2'd0, 32'h10, "R11 count kept");
    // R9 clear wins over push
    @(negedge clk);
    push_valid = 1'b1; push_data = 32'h99;
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 2'd0;
    @(negedge clk);
    push_valid = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
    rd_expect(2'd0, 32'h3, "R9 clear priority");
    // mixed traffic against the model
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      bus_req    = ($urandom % 2) == 0;
      bus_we     = ($urandom % 4) == 0;
      bus_addr   = 2'($urandom % 4);
      bus_wdata  = DW'($urandom % 20);
      push_valid = ($urandom % 3) != 0;
      push_data  = $urandom;
    end
    @(negedge clk);
    bus_req = 1'b0; push_valid = 1'b0;
    repeat (3) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule